// File: doc/BRIEF.md
# CAN Receive Acceptance Filter Router

This block sits behind a CAN bit-level decoder. For every decoded frame, signalled by a one-cycle frame-valid strobe, it decides whether the frame is kept and which of two receive buffers gets it. The decision uses two mask registers and six filter registers. Each of the two buffers has its own receive mode. A first buffer that is already full can be set to spill into the second buffer. The block sends out a store strobe, the target buffer and the number of the filter that matched. It also keeps per-buffer full and overflow flags that the host clears with write pulses. When a frame is stored, its identifier fields are captured.

Filters 0 and 1 use mask 0 and feed buffer 0. Filters 2 to 5 use mask 1 and feed buffer 1. In the mode that takes both frame types, a standard frame is also tested on its first two data bytes against the low sixteen extended-identifier bits of the filter. The buffer memory itself is outside this block: it writes the frame when the store strobe fires.

Top module: `can_accept_router`

## Requirements
- R1: After reset the following are all zero: store strobe, full flags, overflow flags, hit registers, captured fields, and all mask and filter registers.
- R2: A mask bit of 0 makes that identifier bit don't-care. A filter matches when every mask-selected bit equals the incoming bit. A filter whose type bit is 1 only matches extended frames (IDE=1). A filter whose type bit is 0 only matches standard frames (IDE=0). Standard frames compare only the 11-bit SID.
- R3: Each buffer has a 2-bit mode:
  - 00 accepts both frame types on a filter match.
  - 01 accepts only standard frames on a match.
  - 10 accepts only extended frames on a match.
  - 11 accepts every valid frame and reports the buffer's lowest filter (0 or 2) as the hit.
- R4: In mode 00, a standard frame must also match on data: filter EID[15:8] against data byte 0 and EID[7:0] against data byte 1, under the mask's EID[15:0]. In modes 01 and 10 the data bytes have no effect.
- R5: Filters 0–1 and mask 0 select buffer 0. Filters 2–5 and mask 1 select buffer 1. Buffer 0 is evaluated first. Within a buffer the lowest-numbered matching filter wins. The hit code is the filter number in binary (3 bits on the store port).
- R6: One clock after an accepted frame-valid cycle, the block pulses the store strobe for one cycle and presents the buffer (0/1) and hit code. The registered buffer-0 hit (1 bit) or buffer-1 hit (3 bits) updates only on a store to that buffer.
- R7: A store sets the target buffer's full flag. A host clear pulse resets it. A clear pulse in the same cycle as a frame takes effect first, so that frame sees the buffer as empty.
- R8: Spill: if spill is enabled and buffer 0 is effectively full, a frame accepted for buffer 0 goes to buffer 1 instead. The hit code stays 0 or 1.
- R9: A frame accepted for a buffer that is effectively full, with no spill path, sets that buffer's overflow flag and produces no store. The full flag and captured fields stay unchanged. The overflow flag holds until a host clear pulse. A new overflow wins over a clear in the same cycle.
- R10: IDE, RTR, SID, EID and DLC are captured on every store and hold otherwise.
- R11: The config write port maps addresses as follows:
  - Addresses 0–5 write filters with the word {type[29], SID[28:18], EID[17:0]}.
  - Address 6 writes mask 0 and address 7 writes mask 1, each from bits [28:0].
  - A write takes effect from the next cycle. A frame in the same cycle uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxmode0 | input | 2 | Buffer 0 receive mode |
| rxmode1 | input | 2 | Buffer 1 receive mode |
| spill_en | input | 1 | Allow buffer 0 to spill into buffer 1 |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | 3 | Config register select |
| cfg_wdata | input | 30 | Config write word |
| frm_valid | input | 1 | Decoded frame strobe |
| frm_ide | input | 1 | Frame is extended |
| frm_rtr | input | 1 | Frame is a remote request |
| frm_sid | input | 11 | Standard identifier |
| frm_eid | input | 18 | Extended identifier bits |
| frm_data0 | input | 8 | First data byte |
| frm_data1 | input | 8 | Second data byte |
| frm_dlc | input | 4 | Data length code |
| clr_full | input | 2 | Host clear pulses for full flags |
| clr_ovf | input | 2 | Host clear pulses for overflow flags |
| store_stb | output | 1 | Store strobe |
| store_buf | output | 1 | Target buffer of the store |
| store_hit | output | 3 | Matching filter number |
| buf0_hit | output | 1 | Last hit stored into buffer 0 |
| buf1_hit | output | 3 | Last hit stored into buffer 1 |
| full | output | 2 | Buffer full flags |
| ovf | output | 2 | Buffer overflow flags |
| cap_ide | output | 1 | Captured IDE |
| cap_rtr | output | 1 | Captured RTR |
| cap_sid | output | 11 | Captured SID |
| cap_eid | output | 18 | Captured EID |
| cap_dlc | output | 4 | Captured DLC |

## Verification
A host clear of a full or overflow flag can fall in the same cycle as an incoming frame aimed at that buffer. The bench provokes this by raising the clear pulse together with frame-valid, in three cases:
- against a full buffer 0 whose frame must then be stored;
- against a set overflow flag that a fresh overflow must keep set;
- a plain clear that must drop the flag.

A behavioural reference model judges every output on every clock. Named checks confirm the store, target buffer and flag values right after each such cycle.

// File: rtl/can_accept_pkg.sv
package can_accept_pkg;
  localparam int SID_W = 11;
  localparam int EID_W = 18;
  localparam int DATA_CMP_W = 16;

  typedef struct packed {
    logic             ext_sel;
    logic [SID_W-1:0] sid;
    logic [EID_W-1:0] eid;
  } filt_t;

  typedef struct packed {
    logic [SID_W-1:0] sid;
    logic [EID_W-1:0] eid;
  } mask_t;

  typedef enum logic [1:0] {
    RXM_ANY = 2'b00,
    RXM_STD = 2'b01,
    RXM_EXT = 2'b10,
    RXM_ALL = 2'b11
  } rxmode_e;
endpackage

// File: rtl/acc_filter_cmp.sv
module acc_filter_cmp
  import can_accept_pkg::*;
(
  input  filt_t                 filt_i,
  input  mask_t                 mask_i,
  input  logic                  ide_i,
  input  logic [SID_W-1:0]      sid_i,
  input  logic [EID_W-1:0]      eid_i,
  input  logic [DATA_CMP_W-1:0] data_i,
  input  logic                  data_en_i,
  output logic                  hit_o
);
  logic sid_ok;
  logic eid_ok;
  logic data_ok;
  logic std_ok;
  logic ext_ok;

  always_comb begin
    sid_ok  = ((sid_i ^ filt_i.sid) & mask_i.sid) == '0;
    eid_ok  = ((eid_i ^ filt_i.eid) & mask_i.eid) == '0;
    data_ok = !data_en_i ||
              (((data_i ^ filt_i.eid[DATA_CMP_W-1:0]) & mask_i.eid[DATA_CMP_W-1:0]) == '0);
    std_ok  = !ide_i && !filt_i.ext_sel && sid_ok && data_ok;
    ext_ok  = ide_i && filt_i.ext_sel && sid_ok && eid_ok;
    hit_o   = std_ok || ext_ok;
  end
endmodule

// File: rtl/acc_buf_select.sv
module acc_buf_select
  import can_accept_pkg::*;
#(
  parameter int NF    = 2,
  parameter int BASE  = 0,
  parameter int IDX_W = 3
)(
  input  logic [NF-1:0]    hit_i,
  input  rxmode_e          mode_i,
  input  logic             ide_i,
  output logic             acc_o,
  output logic [IDX_W-1:0] idx_o
);
  logic             any_hit;
  logic [IDX_W-1:0] first_idx;

  always_comb begin
    any_hit   = |hit_i;
    first_idx = IDX_W'(BASE);
    for (int k = NF - 1; k >= 0; k--) begin
      if (hit_i[k]) first_idx = IDX_W'(BASE + k);
    end
    unique case (mode_i)
      RXM_ALL: begin acc_o = 1'b1;              idx_o = IDX_W'(BASE); end
      RXM_STD: begin acc_o = any_hit && !ide_i; idx_o = first_idx;    end
      RXM_EXT: begin acc_o = any_hit && ide_i;  idx_o = first_idx;    end
      default: begin acc_o = any_hit;           idx_o = first_idx;    end
    endcase
  end
endmodule

// File: rtl/acc_flag_pair.sv
module acc_flag_pair (
  input  logic clk,
  input  logic rst_n,
  input  logic set_full_i,
  input  logic clr_full_i,
  input  logic set_ovf_i,
  input  logic clr_ovf_i,
  output logic full_o,
  output logic ovf_o
);
  logic full_d;
  logic ovf_d;

  always_comb begin
    full_d = full_o;
    if (clr_full_i) full_d = 1'b0;
    if (set_full_i) full_d = 1'b1;
    ovf_d = ovf_o;
    if (clr_ovf_i) ovf_d = 1'b0;
    if (set_ovf_i) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_o <= 1'b0;
      ovf_o  <= 1'b0;
    end else begin
      full_o <= full_d;
      ovf_o  <= ovf_d;
    end
  end
endmodule

// File: rtl/can_accept_router.sv
module can_accept_router
  import can_accept_pkg::*;
#(
  parameter int NFILT   = 6,
  parameter int NF_BUF0 = 2
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                rxmode0,
  input  logic [1:0]                rxmode1,
  input  logic                      spill_en,
  input  logic                      cfg_we,
  input  logic [$clog2(NFILT+2)-1:0] cfg_addr,
  input  logic [$bits(filt_t)-1:0]  cfg_wdata,
  input  logic                      frm_valid,
  input  logic                      frm_ide,
  input  logic                      frm_rtr,
  input  logic [SID_W-1:0]          frm_sid,
  input  logic [EID_W-1:0]          frm_eid,
  input  logic [7:0]                frm_data0,
  input  logic [7:0]                frm_data1,
  input  logic [3:0]                frm_dlc,
  input  logic [1:0]                clr_full,
  input  logic [1:0]                clr_ovf,
  output logic                      store_stb,
  output logic                      store_buf,
  output logic [$clog2(NFILT)-1:0]  store_hit,
  output logic                      buf0_hit,
  output logic [$clog2(NFILT)-1:0]  buf1_hit,
  output logic [1:0]                full,
  output logic [1:0]                ovf,
  output logic                      cap_ide,
  output logic                      cap_rtr,
  output logic [SID_W-1:0]          cap_sid,
  output logic [EID_W-1:0]          cap_eid,
  output logic [3:0]                cap_dlc
);
  localparam int NF_BUF1 = NFILT - NF_BUF0;
  localparam int HIT_W   = $clog2(NFILT);
  localparam int ADDR_W  = $clog2(NFILT + 2);
  localparam int NBUF    = 2;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // configuration registers
  filt_t filt_q [NFILT];
  mask_t mask_q [NBUF];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      for (int n = 0; n < NFILT; n++) filt_q[n] <= '0;
      for (int b = 0; b < NBUF; b++)  mask_q[b] <= '0;
    end else if (cfg_we) begin
      for (int n = 0; n < NFILT; n++) begin
        if (cfg_addr == ADDR_W'(n)) filt_q[n] <= filt_t'(cfg_wdata);
      end
      for (int b = 0; b < NBUF; b++) begin
        if (cfg_addr == ADDR_W'(NFILT + b)) mask_q[b] <= mask_t'(cfg_wdata[$bits(mask_t)-1:0]);
      end
    end
  end

  // comparator bank
  rxmode_e          mode_w [NBUF];
  logic [NFILT-1:0] hit_vec;

  assign mode_w[0] = rxmode_e'(rxmode0);
  assign mode_w[1] = rxmode_e'(rxmode1);

  for (genvar n = 0; n < NFILT; n++) begin : g_cmp
    localparam int BI = (n < NF_BUF0) ? 0 : 1;
    acc_filter_cmp u_cmp (
      .filt_i   (filt_q[n]),
      .mask_i   (mask_q[BI]),
      .ide_i    (frm_ide),
      .sid_i    (frm_sid),
      .eid_i    (frm_eid),
      .data_i   ({frm_data0, frm_data1}),
      .data_en_i(mode_w[BI] == RXM_ANY),
      .hit_o    (hit_vec[n])
    );
  end

  logic             acc0;
  logic             acc1;
  logic [HIT_W-1:0] idx0;
  logic [HIT_W-1:0] idx1;

  acc_buf_select #(.NF(NF_BUF0), .BASE(0), .IDX_W(HIT_W)) u_sel0 (
    .hit_i (hit_vec[NF_BUF0-1:0]),
    .mode_i(mode_w[0]),
    .ide_i (frm_ide),
    .acc_o (acc0),
    .idx_o (idx0)
  );

  acc_buf_select #(.NF(NF_BUF1), .BASE(NF_BUF0), .IDX_W(HIT_W)) u_sel1 (
    .hit_i (hit_vec[NFILT-1:NF_BUF0]),
    .mode_i(mode_w[1]),
    .ide_i (frm_ide),
    .acc_o (acc1),
    .idx_o (idx1)
  );

  // routing decision
  logic [1:0]       full_eff;
  logic             st_d;
  logic             sbuf_d;
  logic [HIT_W-1:0] shit_d;
  logic [1:0]       set_full;
  logic [1:0]       set_ovf;

  always_comb begin
    full_eff = full & ~clr_full;
    st_d     = 1'b0;
    sbuf_d   = 1'b0;
    shit_d   = '0;
    set_full = 2'b00;
    set_ovf  = 2'b00;
    if (frm_valid) begin
      if (acc0) begin
        if (!full_eff[0]) begin
          st_d = 1'b1; sbuf_d = 1'b0; shit_d = idx0;
        end else if (spill_en) begin
          if (!full_eff[1]) begin
            st_d = 1'b1; sbuf_d = 1'b1; shit_d = idx0;
          end else begin
            set_ovf[1] = 1'b1;
          end
        end else begin
          set_ovf[0] = 1'b1;
        end
      end else if (acc1) begin
        if (!full_eff[1]) begin
          st_d = 1'b1; sbuf_d = 1'b1; shit_d = idx1;
        end else begin
          set_ovf[1] = 1'b1;
        end
      end
    end
    if (st_d) set_full[sbuf_d] = 1'b1;
  end

  for (genvar b = 0; b < NBUF; b++) begin : g_flag
    acc_flag_pair u_flag (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .set_full_i(set_full[b]),
      .clr_full_i(clr_full[b]),
      .set_ovf_i (set_ovf[b]),
      .clr_ovf_i (clr_ovf[b]),
      .full_o    (full[b]),
      .ovf_o     (ovf[b])
    );
  end

  // output and capture registers
  logic             buf0_hit_d;
  logic [HIT_W-1:0] buf1_hit_d;
  logic             cap_ide_d;
  logic             cap_rtr_d;
  logic [SID_W-1:0] cap_sid_d;
  logic [EID_W-1:0] cap_eid_d;
  logic [3:0]       cap_dlc_d;

  always_comb begin
    buf0_hit_d = (st_d && !sbuf_d) ? shit_d[0] : buf0_hit;
    buf1_hit_d = (st_d &&  sbuf_d) ? shit_d    : buf1_hit;
    cap_ide_d  = st_d ? frm_ide : cap_ide;
    cap_rtr_d  = st_d ? frm_rtr : cap_rtr;
    cap_sid_d  = st_d ? frm_sid : cap_sid;
    cap_eid_d  = st_d ? frm_eid : cap_eid;
    cap_dlc_d  = st_d ? frm_dlc : cap_dlc;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      store_stb <= 1'b0;
      store_buf <= 1'b0;
      store_hit <= '0;
      buf0_hit  <= 1'b0;
      buf1_hit  <= '0;
      cap_ide   <= 1'b0;
      cap_rtr   <= 1'b0;
      cap_sid   <= '0;
      cap_eid   <= '0;
      cap_dlc   <= '0;
    end else begin
      store_stb <= st_d;
      store_buf <= sbuf_d;
      store_hit <= shit_d;
      buf0_hit  <= buf0_hit_d;
      buf1_hit  <= buf1_hit_d;
      cap_ide   <= cap_ide_d;
      cap_rtr   <= cap_rtr_d;
      cap_sid   <= cap_sid_d;
      cap_eid   <= cap_eid_d;
      cap_dlc   <= cap_dlc_d;
    end
  end
endmodule

// File: rtl/can_accept_router_chk.sv
module can_accept_router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        frm_valid,
  input logic [1:0]  clr_full,
  input logic [1:0]  clr_ovf,
  input logic        store_stb,
  input logic        store_buf,
  input logic [2:0]  store_hit,
  input logic [1:0]  full,
  input logic [1:0]  ovf,
  input logic [10:0] cap_sid,
  input logic [17:0] cap_eid,
  input logic [3:0]  cap_dlc
);
  assert_store_needs_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    store_stb |-> $past(frm_valid));

  assert_store_sets_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    store_stb |-> full[store_buf]);

  assert_full0_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full[0] && !clr_full[0]) |=> full[0]);

  assert_full1_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full[1] && !clr_full[1]) |=> full[1]);

  assert_ovf0_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf[0] && !clr_ovf[0]) |=> ovf[0]);

  assert_ovf1_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf[1] && !clr_ovf[1]) |=> ovf[1]);

  assert_hit_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    store_stb |-> (store_hit <= 3'd5));

  assert_buf1_only_direct_hits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (store_stb && !store_buf) |-> (store_hit <= 3'd1));

  assert_capture_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !store_stb |-> ($stable(cap_sid) && $stable(cap_eid) && $stable(cap_dlc)));
endmodule

bind can_accept_router can_accept_router_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .frm_valid(frm_valid),
  .clr_full (clr_full),
  .clr_ovf  (clr_ovf),
  .store_stb(store_stb),
  .store_buf(store_buf),
  .store_hit(store_hit),
  .full     (full),
  .ovf      (ovf),
  .cap_sid  (cap_sid),
  .cap_eid  (cap_eid),
  .cap_dlc  (cap_dlc)
);

// File: tb/can_accept_router_bench.sv
`timescale 1ns/1ps
module can_accept_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  rxmode0 = 2'b00, rxmode1 = 2'b00;
  logic        spill_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = 3'd0;
  logic [29:0] cfg_wdata = 30'd0;
  logic        frm_valid = 1'b0, frm_ide = 1'b0, frm_rtr = 1'b0;
  logic [10:0] frm_sid = 11'd0;
  logic [17:0] frm_eid = 18'd0;
  logic [7:0]  frm_data0 = 8'd0, frm_data1 = 8'd0;
  logic [3:0]  frm_dlc = 4'd0;
  logic [1:0]  clr_full = 2'b00, clr_ovf = 2'b00;
  logic        store_stb, store_buf, buf0_hit, cap_ide, cap_rtr;
  logic [2:0]  store_hit, buf1_hit;
  logic [1:0]  full, ovf;
  logic [10:0] cap_sid;
  logic [17:0] cap_eid;
  logic [3:0]  cap_dlc;

  always #2 clk = ~clk;

  can_accept_router u_can_accept_router (
    .clk(clk), .rst_n(rst_n), .rxmode0(rxmode0), .rxmode1(rxmode1),
    .spill_en(spill_en), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .frm_valid(frm_valid), .frm_ide(frm_ide), .frm_rtr(frm_rtr), .frm_sid(frm_sid),
    .frm_eid(frm_eid), .frm_data0(frm_data0), .frm_data1(frm_data1), .frm_dlc(frm_dlc),
    .clr_full(clr_full), .clr_ovf(clr_ovf), .store_stb(store_stb), .store_buf(store_buf),
    .store_hit(store_hit), .buf0_hit(buf0_hit), .buf1_hit(buf1_hit), .full(full),
    .ovf(ovf), .cap_ide(cap_ide), .cap_rtr(cap_rtr), .cap_sid(cap_sid),
    .cap_eid(cap_eid), .cap_dlc(cap_dlc)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // reference model state
  int f_ext[6], f_sid[6], f_eid[6], m_sid[2], m_eid[2];
  int e_full[2], e_ovf[2];
  int e_stb, e_buf, e_hit, e_hit0, e_hit1, e_ide, e_rtr, e_sid, e_eid, e_dlc;

  function automatic bit fmatch(int n, int b, bit use_data);
    int dat;
    dat = frm_data0 * 256 + frm_data1;
    if (((frm_sid ^ f_sid[n]) & m_sid[b]) != 0) return 0;
    if (!frm_ide) begin
      if (f_ext[n] != 0) return 0;
      if (use_data && (((dat ^ f_eid[n]) & m_eid[b] & 16'hFFFF) != 0)) return 0;
      return 1;
    end
    if (f_ext[n] == 0) return 0;
    return ((frm_eid ^ f_eid[n]) & m_eid[b]) == 0;
  endfunction

  task automatic pick(input int b, output int acc, output int idx);
    int md, lo, hi;
    md = (b == 0) ? rxmode0 : rxmode1;
    lo = (b == 0) ? 0 : 2;
    hi = (b == 0) ? 1 : 5;
    acc = 0; idx = lo;
    if (md == 3) begin acc = 1; return; end
    if (md == 1 && frm_ide) return;
    if (md == 2 && !frm_ide) return;
    for (int n = lo; n <= hi; n++)
      if (acc == 0 && fmatch(n, b, md == 0)) begin acc = 1; idx = n; end
  endtask

  task automatic model_reset();
    for (int n = 0; n < 6; n++) begin f_ext[n] = 0; f_sid[n] = 0; f_eid[n] = 0; end
    for (int b = 0; b < 2; b++) begin m_sid[b] = 0; m_eid[b] = 0; e_full[b] = 0; e_ovf[b] = 0; end
    e_stb = 0; e_buf = 0; e_hit = 0; e_hit0 = 0; e_hit1 = 0;
    e_ide = 0; e_rtr = 0; e_sid = 0; e_eid = 0; e_dlc = 0;
  endtask

  task automatic model_step();
    int a0, i0, a1, i1, fe0, fe1, tb, sov0, sov1, store;
    pick(0, a0, i0);
    pick(1, a1, i1);
    fe0 = e_full[0] && !clr_full[0];
    fe1 = e_full[1] && !clr_full[1];
    store = 0; tb = 0; sov0 = 0; sov1 = 0; e_hit = 0;
    if (frm_valid) begin
      if (a0) begin
        if (!fe0) begin store = 1; tb = 0; e_hit = i0; end
        else if (spill_en && !fe1) begin store = 1; tb = 1; e_hit = i0; end
        else if (spill_en) sov1 = 1;
        else sov0 = 1;
      end else if (a1) begin
        if (!fe1) begin store = 1; tb = 1; e_hit = i1; end
        else sov1 = 1;
      end
    end
    for (int b = 0; b < 2; b++) begin
      if (clr_full[b]) e_full[b] = 0;
      if (clr_ovf[b]) e_ovf[b] = 0;
    end
    if (sov0) e_ovf[0] = 1;
    if (sov1) e_ovf[1] = 1;
    e_stb = store; e_buf = tb;
    if (store) begin
      e_full[tb] = 1;
      if (tb == 0) e_hit0 = e_hit; else e_hit1 = e_hit;
      e_ide = frm_ide; e_rtr = frm_rtr; e_sid = frm_sid; e_eid = frm_eid; e_dlc = frm_dlc;
    end
    if (cfg_we) begin
      if (cfg_addr < 6) begin
        f_ext[cfg_addr] = cfg_wdata[29]; f_sid[cfg_addr] = cfg_wdata[28:18]; f_eid[cfg_addr] = cfg_wdata[17:0];
      end else begin
        m_sid[cfg_addr-6] = cfg_wdata[28:18]; m_eid[cfg_addr-6] = cfg_wdata[17:0];
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  task automatic cmp(input string req, input string nm, input int act, input int exp);
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, nm, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      cmp("R6", "store_stb", store_stb, e_stb);
      if (e_stb) begin
        cmp("R5", "store_buf", store_buf, e_buf);
        cmp("R5", "store_hit", store_hit, e_hit);
      end
      cmp("R6", "buf0_hit", buf0_hit, e_hit0);
      cmp("R6", "buf1_hit", buf1_hit, e_hit1);
      cmp("R7", "full0", full[0], e_full[0]);
      cmp("R7", "full1", full[1], e_full[1]);
      cmp("R9", "ovf0", ovf[0], e_ovf[0]);
      cmp("R9", "ovf1", ovf[1], e_ovf[1]);
      cmp("R10", "cap_ide", cap_ide, e_ide);
      cmp("R10", "cap_rtr", cap_rtr, e_rtr);
      cmp("R10", "cap_sid", cap_sid, e_sid);
      cmp("R10", "cap_eid", cap_eid, e_eid);
      cmp("R10", "cap_dlc", cap_dlc, e_dlc);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cfg_write(input int addr, input logic [29:0] w);
    cfg_we = 1; cfg_addr = 3'(addr); cfg_wdata = w;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic frame(input bit ide, input bit rtr, input int sid, input int eid,
                       input int d0, input int d1, input int dlc,
                       input logic [1:0] cf, input logic [1:0] co);
    frm_valid = 1; frm_ide = ide; frm_rtr = rtr; frm_sid = 11'(sid); frm_eid = 18'(eid);
    frm_data0 = 8'(d0); frm_data1 = 8'(d1); frm_dlc = 4'(dlc);
    clr_full = cf; clr_ovf = co;
    @(negedge clk);
    frm_valid = 0; clr_full = 2'b00; clr_ovf = 2'b00; cfg_we = 0;
  endtask

  task automatic clear_all();
    clr_full = 2'b11; clr_ovf = 2'b11;
    @(negedge clk);
    clr_full = 2'b00; clr_ovf = 2'b00;
  endtask

  task automatic summary();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 store_stb", store_stb, 0);
    chk("R1 full", full, 0);
    chk("R1 ovf", ovf, 0);
    chk("R1 cap_sid", cap_sid, 0);

    // R11 programming: masks at 6/7, filters at 0..5, word {type,sid,eid}
    cfg_write(6, {1'b0, 11'h7FF, 18'h3FFFF});
    cfg_write(7, {1'b0, 11'h7F0, 18'h3FFFF});
    cfg_write(0, {1'b0, 11'h123, 18'h0ABCD});
    cfg_write(1, {1'b1, 11'h055, 18'h20001});
    cfg_write(2, {1'b0, 11'h300, 18'h0});
    cfg_write(3, {1'b0, 11'h310, 18'h0});
    cfg_write(4, {1'b1, 11'h400, 18'h3FFFF});
    cfg_write(5, {1'b0, 11'h300, 18'h0});

    // R4 mode 00 standard frame with matching data bytes
    frame(0, 0, 'h123, 0, 'hAB, 'hCD, 8, 2'b00, 2'b00);
    chk("R4 store_stb", store_stb, 1);
    chk("R5 store_buf", store_buf, 0);
    chk("R5 store_hit", store_hit, 0);
    chk("R7 full0 set", full[0], 1);
    // R4 data mismatch rejects
    frame(0, 0, 'h123, 0, 'hAB, 'hCE, 8, 2'b00, 2'b00);
    chk("R4 data mismatch no store", store_stb, 0);
    // R2 R5 masked bits don't care, lowest filter (2 over 5)
    frame(0, 0, 'h305, 0, 0, 0, 2, 2'b00, 2'b00);
    chk("R2 masked match store", store_stb, 1);
    chk("R5 buf1 target", store_buf, 1);
    chk("R5 lowest filter wins", store_hit, 2);
    chk("R6 buf1_hit", buf1_hit, 2);
    clear_all();
    chk("R7 host clear", full, 0);
    // R2 R10 extended frame to filter 1, capture
    frame(1, 1, 'h055, 'h20001, 0, 0, 5, 2'b00, 2'b00);
    chk("R2 ext hit1", store_hit, 1);
    chk("R6 buf0_hit", buf0_hit, 1);
    chk("R10 cap_ide", cap_ide, 1);
    chk("R10 cap_rtr", cap_rtr, 1);
    chk("R10 cap_eid", cap_eid, 'h20001);
    chk("R10 cap_dlc", cap_dlc, 5);
    clear_all();

    // R3 mode 01: extended rejected, data ignored for standard
    rxmode0 = 2'b01;
    frame(1, 0, 'h055, 'h20001, 0, 0, 1, 2'b00, 2'b00);
    chk("R3 std-only rejects ext", store_stb, 0);
    frame(0, 0, 'h123, 0, 'h11, 'h22, 1, 2'b00, 2'b00);
    chk("R4 data ignored in 01", store_stb, 1);
    chk("R4 data ignored buf", store_buf, 0);
    clear_all();
    // R3 mode 11 takes everything, hit = 0
    rxmode0 = 2'b11;
    frame(1, 0, 'h7FF, 'h12345, 0, 0, 3, 2'b00, 2'b00);
    chk("R3 accept all", store_stb, 1);
    chk("R3 accept all hit", store_hit, 0);
    clear_all();
    // R3 mode 10 on buffer 1
    rxmode0 = 2'b00; rxmode1 = 2'b10;
    frame(0, 0, 'h310, 0, 0, 0, 1, 2'b00, 2'b00);
    chk("R3 ext-only rejects std", store_stb, 0);
    frame(1, 0, 'h40A, 'h3FFFF, 0, 0, 1, 2'b00, 2'b00);
    chk("R3 ext-only hit4", store_hit, 4);
    chk("R3 ext-only buf", store_buf, 1);
    clear_all();
    rxmode1 = 2'b00;

    // R9 overflow without spill
    frame(0, 0, 'h123, 0, 'hAB, 'hCD, 8, 2'b00, 2'b00);
    frame(0, 0, 'h123, 0, 'hAB, 'hCD, 3, 2'b00, 2'b00);
    chk("R9 no store on overflow", store_stb, 0);
    chk("R9 ovf0 set", ovf[0], 1);
    chk("R9 full0 kept", full[0], 1);
    chk("R10 capture kept", cap_dlc, 8);
    // R8 spill into buffer 1 keeps hit 1
    spill_en = 1;
    frame(1, 0, 'h055, 'h20001, 0, 0, 6, 2'b00, 2'b00);
    chk("R8 spill stored", store_stb, 1);
    chk("R8 spill buf", store_buf, 1);
    chk("R8 spill hit", buf1_hit, 1);
    frame(1, 0, 'h055, 'h20001, 0, 0, 6, 2'b00, 2'b00);
    chk("R9 ovf1 after spill full", ovf[1], 1);
    chk("R9 no store", store_stb, 0);
    // R7 clear and frame same cycle
    spill_en = 0;
    frame(0, 0, 'h123, 0, 'hAB, 'hCD, 7, 2'b01, 2'b00);
    chk("R7 same-cycle clear store", store_stb, 1);
    chk("R7 same-cycle clear buf", store_buf, 0);
    chk("R7 full0 stays set", full[0], 1);
    // R9 overflow set wins over clear
    frame(0, 0, 'h123, 0, 'hAB, 'hCD, 7, 2'b00, 2'b01);
    chk("R9 set beats clear", ovf[0], 1);
    clr_ovf = 2'b01;
    @(negedge clk);
    clr_ovf = 2'b00;
    chk("R9 clear drops ovf0", ovf[0], 0);
    clear_all();

    // R11 write and frame in the same cycle: old filter used
    cfg_we = 1; cfg_addr = 3'd0; cfg_wdata = {1'b0, 11'h124, 18'h0ABCD};
    frame(0, 0, 'h124, 0, 'hAB, 'hCD, 2, 2'b00, 2'b00);
    chk("R11 old filter in write cycle", store_stb, 0);
    frame(0, 0, 'h124, 0, 'hAB, 'hCD, 2, 2'b00, 2'b00);
    chk("R11 new filter next cycle", store_stb, 1);
    chk("R11 new filter hit", store_hit, 0);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule